// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block watches a bank of external pins and raises one interrupt line per pin. Each pin passes through a two-flop synchronizer. The synchronized value is then compared with its value on the previous clock to find rising and falling edges. Every channel is either edge-sensitive or level-sensitive, set by one mode bit. Software controls the block through a small word-addressed register bus. Writes take effect on the clock edge. Reads are combinational and have no side effects.

Each channel has two enable bits. The first enable bit arms rising edges in edge mode, and turns the channel on in level mode. The second enable bit has two meanings:
- In edge mode, it arms falling edges.
- In level mode, it picks the active polarity.

Each enable register also has a set alias and a clear alias, both write-only, so software can change single bits without a read-modify-write.

Two sticky latch registers record every rising and falling edge, whatever the enables are. Pending edge interrupts are held in a status register, and software clears them by writing 1 to a bit. Level interrupts are not held: they follow the pin.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0 and every `irq_o` bit is 0.
- R2: Offsets 0x00 (mode), 0x04 (rise/enable) and 0x10 (fall/polarity) can be written and read back. Bit n belongs to channel n. Bits 31:8 of any read are 0, and an unmapped offset reads 0 and ignores writes.
- R3: Writing to 0x08 or 0x14 sets the enable bits of 0x04 or 0x10 where the data bit is 1. Writing to 0x0C or 0x18 clears them where the data bit is 1. Bits written as 0 are unchanged, and all four aliases read as 0.
- R4: The rise latch (0x1C) and the fall latch (0x20) set a bit on every synchronized edge of that channel, in either mode and whatever the enables are. Writing 1 to a latch bit clears it, and writing 0 has no effect.
- R5: In edge mode (mode bit 0), a status bit sets on a rising edge when the 0x04 bit is 1, or on a falling edge when the 0x10 bit is 1. `irq_o[n]` equals the status bit and stays high until the bit is cleared.
- R6: Writing 1 to a bit of the status register at 0x24 clears a pending edge interrupt, and writing 0 leaves it unchanged.
- R7: If an edge arrives on the same clock as a write-1 clear of its latch bit or status bit, the bit stays set.
- R8: In level mode (mode bit 1), `irq_o[n]` is the 0x04 bit ANDed with the synchronized pin. The pin is inverted when the 0x10 bit is 0. Nothing is held, and status bit n reads the same value as `irq_o[n]`.
- R9: A pin change applied before clock edge k shows in the latches and edge status after edge k+2, and in a level-mode `irq_o` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous pin inputs, one per channel |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 8 | Byte address of the register (word offsets) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq_o | output | 8 | Interrupt request per channel |

## Verification
The checker watches these on every cycle:
- Reset silences the outputs.
- Reserved read bits stay zero.
- A set-alias write always lands in its enable register.
- Every synchronized edge reaches its latch, even against a clear on the same cycle.
- A latch or status bit never appears without an edge that caused it.
- An edge interrupt stays up until a status write or a mode write.
- A level-mode channel never holds a status bit.

Some behaviour only the bench scenarios can show, by comparing against a cycle model of the pin pipeline:
- the exact latency from a pin to its output;
- the polarity choice in level mode;
- the clear aliases and the unmapped offsets;
- the value each register reads back after random mixes of writes and pin toggles.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RISE_EN  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FALL_EN  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RISE_LAT = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_FALL_LAT = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h24;

    typedef enum logic [3:0] {
        SEL_MODE,
        SEL_RISE_EN,
        SEL_RISE_SET,
        SEL_RISE_CLR,
        SEL_FALL_EN,
        SEL_FALL_SET,
        SEL_FALL_CLR,
        SEL_RISE_LAT,
        SEL_FALL_LAT,
        SEL_STATUS,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic             we;
        reg_sel_e         sel;
        logic [BUS_W-1:0] data;
    } bus_cmd_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_MODE:     s = SEL_MODE;
            OFS_RISE_EN:  s = SEL_RISE_EN;
            OFS_RISE_SET: s = SEL_RISE_SET;
            OFS_RISE_CLR: s = SEL_RISE_CLR;
            OFS_FALL_EN:  s = SEL_FALL_EN;
            OFS_FALL_SET: s = SEL_FALL_SET;
            OFS_FALL_CLR: s = SEL_FALL_CLR;
            OFS_RISE_LAT: s = SEL_RISE_LAT;
            OFS_FALL_LAT: s = SEL_FALL_LAT;
            OFS_STATUS:   s = SEL_STATUS;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pic_edge_det.sv
module pic_edge_det #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    assign rise = cur & ~prev_q;
    assign fall = ~cur & prev_q;
endmodule

// File: rtl/pic_chan.sv
module pic_chan (
    input  logic clk,
    input  logic rst,
    input  logic mode_lvl,
    input  logic en_a,
    input  logic en_b,
    input  logic pin,
    input  logic rise,
    input  logic fall,
    input  logic clr,
    output logic pend_q,
    output logic irq
);
    logic hit;
    logic lvl_act;

    assign hit     = (rise & en_a) | (fall & en_b);
    assign lvl_act = en_a & (en_b ? pin : ~pin);

    always_ff @(posedge clk) begin
        if (rst)           pend_q <= 1'b0;
        else if (mode_lvl) pend_q <= 1'b0;
        else               pend_q <= (pend_q & ~clr) | hit;
    end

    assign irq = mode_lvl ? lvl_act : pend_q;
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd,
    input  logic [NCH-1:0]   rise,
    input  logic [NCH-1:0]   fall,
    input  logic [NCH-1:0]   irq_view,
    output logic [NCH-1:0]   mode_q,
    output logic [NCH-1:0]   en_r_q,
    output logic [NCH-1:0]   en_f_q,
    output logic [NCH-1:0]   rlat_q,
    output logic [NCH-1:0]   flat_q,
    output logic [NCH-1:0]   st_clr,
    output logic [BUS_W-1:0] rd_data
);
    localparam int unsigned PAD = BUS_W - NCH;

    logic [NCH-1:0] wd;
    logic [NCH-1:0] rlat_clr;
    logic [NCH-1:0] flat_clr;

    assign wd       = cmd.data[NCH-1:0];
    assign rlat_clr = (cmd.we && cmd.sel == SEL_RISE_LAT) ? wd : '0;
    assign flat_clr = (cmd.we && cmd.sel == SEL_FALL_LAT) ? wd : '0;
    assign st_clr   = (cmd.we && cmd.sel == SEL_STATUS)   ? wd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            en_r_q <= '0;
            en_f_q <= '0;
        end else if (cmd.we) begin
            case (cmd.sel)
                SEL_MODE:     mode_q <= wd;
                SEL_RISE_EN:  en_r_q <= wd;
                SEL_RISE_SET: en_r_q <= en_r_q | wd;
                SEL_RISE_CLR: en_r_q <= en_r_q & ~wd;
                SEL_FALL_EN:  en_f_q <= wd;
                SEL_FALL_SET: en_f_q <= en_f_q | wd;
                SEL_FALL_CLR: en_f_q <= en_f_q & ~wd;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rlat_q <= '0;
            flat_q <= '0;
        end else begin
            rlat_q <= (rlat_q & ~rlat_clr) | rise;
            flat_q <= (flat_q & ~flat_clr) | fall;
        end
    end

    always_comb begin
        logic [NCH-1:0] v;
        case (cmd.sel)
            SEL_MODE:     v = mode_q;
            SEL_RISE_EN:  v = en_r_q;
            SEL_FALL_EN:  v = en_f_q;
            SEL_RISE_LAT: v = rlat_q;
            SEL_FALL_LAT: v = flat_q;
            SEL_STATUS:   v = irq_view;
            default:      v = '0;
        endcase
        rd_data = {{PAD{1'b0}}, v};
    end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned NCH         = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    pin_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    output logic [NCH-1:0]    irq_o
);
    bus_cmd_t       cmd;
    logic [NCH-1:0] pin_s;
    logic [NCH-1:0] rise_p;
    logic [NCH-1:0] fall_p;
    logic [NCH-1:0] mode_q;
    logic [NCH-1:0] en_r_q;
    logic [NCH-1:0] en_f_q;
    logic [NCH-1:0] rlat_q;
    logic [NCH-1:0] flat_q;
    logic [NCH-1:0] st_clr;
    logic [NCH-1:0] sts_q;
    logic [NCH-1:0] irq_w;

    assign cmd.we   = wr_en;
    assign cmd.sel  = decode_addr(addr);
    assign cmd.data = wr_data;

    pic_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_i),
        .dout (pin_s)
    );

    pic_edge_det #(.W(NCH)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .cur  (pin_s),
        .rise (rise_p),
        .fall (fall_p)
    );

    pic_regs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .rise     (rise_p),
        .fall     (fall_p),
        .irq_view (irq_w),
        .mode_q   (mode_q),
        .en_r_q   (en_r_q),
        .en_f_q   (en_f_q),
        .rlat_q   (rlat_q),
        .flat_q   (flat_q),
        .st_clr   (st_clr),
        .rd_data  (rd_data)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pic_chan u_ch (
            .clk      (clk),
            .rst      (rst),
            .mode_lvl (mode_q[n]),
            .en_a     (en_r_q[n]),
            .en_b     (en_f_q[n]),
            .pin      (pin_s[n]),
            .rise     (rise_p[n]),
            .fall     (fall_p[n]),
            .clr      (st_clr[n]),
            .pend_q   (sts_q[n]),
            .irq      (irq_w[n])
        );
    end

    assign irq_o = irq_w;
endmodule

// File: rtl/pin_irq_ctrl_sva.sv
module pin_irq_ctrl_sva
    import pic_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  wr_data,
    input logic [BUS_W-1:0]  rd_data,
    input logic [NCH-1:0]    irq_o,
    input logic [NCH-1:0]    rise_p,
    input logic [NCH-1:0]    fall_p,
    input logic [NCH-1:0]    mode_q,
    input logic [NCH-1:0]    en_r_q,
    input logic [NCH-1:0]    en_f_q,
    input logic [NCH-1:0]    rlat_q,
    input logic [NCH-1:0]    sts_q
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (irq_o == '0));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[BUS_W-1:NCH] == '0);

    p_set_alias_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_RISE_SET) |=>
        ((en_r_q & $past(wr_data[NCH-1:0])) == $past(wr_data[NCH-1:0])));

    p_rise_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (|rise_p) |=> ((rlat_q & $past(rise_p)) == $past(rise_p)));

    p_rise_origin_r4: assert property (@(posedge clk) disable iff (rst)
        (rlat_q & ~$past(rlat_q) & ~$past(rise_p)) == '0);

    p_status_origin_r5: assert property (@(posedge clk) disable iff (rst)
        (sts_q & ~$past(sts_q) &
         ~$past((rise_p & en_r_q) | (fall_p & en_f_q))) == '0);

    p_edge_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (addr == OFS_STATUS || addr == OFS_MODE)) |=>
        (($past(irq_o & ~mode_q) & ~irq_o) == '0));

    p_edge_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_RISE_LAT && |(rise_p & wr_data[NCH-1:0])) |=>
        ((rlat_q & $past(rise_p & wr_data[NCH-1:0])) ==
         $past(rise_p & wr_data[NCH-1:0])));

    p_level_no_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_q & mode_q & $past(mode_q)) == '0);
endmodule

bind pin_irq_ctrl pin_irq_ctrl_sva #(.NCH(NCH)) u_sva (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_o   (irq_o),
    .rise_p  (rise_p),
    .fall_p  (fall_p),
    .mode_q  (mode_q),
    .en_r_q  (en_r_q),
    .en_f_q  (en_f_q),
    .rlat_q  (rlat_q),
    .sts_q   (sts_q)
);

// File: tb/pin_irq_ctrl_tb.sv
module pin_irq_ctrl_tb;
    localparam time HALF = 2.5ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_i = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // model state (after the most recent clock edge)
    logic [7:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [7:0] m_mode = '0, m_enr = '0, m_enf = '0;
    logic [7:0] m_rl = '0, m_fl = '0, m_st = '0;
    logic [7:0] cur_pins = '0;

    always #HALF clk = ~clk;

    pin_irq_ctrl u_dut (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pin_i),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    function automatic logic [7:0] exp_irq();
        logic [7:0] lvl;
        lvl = m_enr & ~(m_enf ^ m_s2);
        return (m_mode & lvl) | (~m_mode & m_st);
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return {24'd0, m_mode};
            8'h04: return {24'd0, m_enr};
            8'h10: return {24'd0, m_enf};
            8'h1C: return {24'd0, m_rl};
            8'h20: return {24'd0, m_fl};
            8'h24: return {24'd0, exp_irq()};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00, 8'h04, 8'h10: return "R2";
            8'h08, 8'h0C, 8'h14, 8'h18: return "R3";
            8'h1C, 8'h20: return "R4 R7 R9";
            8'h24: return "R6 R5 R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one bus/pin cycle at a negedge, step the model across the edge,
    // then read raddr at the next negedge and compare.
    task automatic cycle(input logic [7:0] pins, input logic we, input logic [7:0] a,
                         input logic [31:0] d, input logic [7:0] raddr);
        logic [7:0] rise, fall, hit, wd, rclr, fclr, sclr;
        logic [7:0] n_mode, n_enr, n_enf;
        pin_i = pins; wr_en = we; addr = a; wr_data = d;
        cur_pins = pins;
        wd   = d[7:0];
        rise = m_s2 & ~m_prev;
        fall = ~m_s2 & m_prev;
        rclr = (we && a == 8'h1C) ? wd : '0;
        fclr = (we && a == 8'h20) ? wd : '0;
        sclr = (we && a == 8'h24) ? wd : '0;
        hit  = (rise & m_enr) | (fall & m_enf);
        n_mode = m_mode; n_enr = m_enr; n_enf = m_enf;
        if (we) begin
            case (a)
                8'h00: n_mode = wd;
                8'h04: n_enr = wd;
                8'h08: n_enr = m_enr | wd;
                8'h0C: n_enr = m_enr & ~wd;
                8'h10: n_enf = wd;
                8'h14: n_enf = m_enf | wd;
                8'h18: n_enf = m_enf & ~wd;
                default: ;
            endcase
        end
        @(posedge clk);
        m_st   = ((m_st & ~sclr) | hit) & ~m_mode;
        m_rl   = (m_rl & ~rclr) | rise;
        m_fl   = (m_fl & ~fclr) | fall;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        m_mode = n_mode; m_enr = n_enr; m_enf = n_enf;
        @(negedge clk);
        wr_en = 1'b0; addr = raddr;
        #1;
        check(tag_of(raddr), rd_data, exp_read(raddr));
        check("R5 R8 irq", {24'd0, irq_o}, {24'd0, exp_irq()});
    endtask

    task automatic idle(input int n, input logic [7:0] raddr);
        for (int i = 0; i < n; i++) cycle(cur_pins, 1'b0, 8'h00, 32'd0, raddr);
    endtask

    function automatic logic [7:0] pick_addr(input int unsigned r);
        case (r % 12)
            0: return 8'h00;  1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;
            4: return 8'h10;  5: return 8'h14;  6: return 8'h18;  7: return 8'h1C;
            8: return 8'h20;  9: return 8'h24; 10: return 8'h28; default: return 8'h24;
        endcase
    endfunction

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset values of every offset and of the outputs
        for (int i = 0; i < 11; i++) begin
            addr = 8'(i * 4);
            #1;
            check("R1", rd_data, 32'd0);
        end
        check("R1 irq", {24'd0, irq_o}, 32'd0);

        // R2: full-width write, reserved bits read 0; unmapped offset ignored
        cycle(8'h00, 1'b1, 8'h00, 32'hFFFF_FF00, 8'h00);
        cycle(8'h00, 1'b1, 8'h04, 32'hFFFF_FF5A, 8'h04);
        cycle(8'h00, 1'b1, 8'h28, 32'hFFFF_FFFF, 8'h28);
        // R3: set and clear aliases act bitwise and read as zero
        cycle(8'h00, 1'b1, 8'h08, 32'h0000_0081, 8'h04);
        cycle(8'h00, 1'b1, 8'h0C, 32'h0000_0018, 8'h04);
        cycle(8'h00, 1'b1, 8'h14, 32'h0000_00F0, 8'h10);
        cycle(8'h00, 1'b1, 8'h18, 32'h0000_0030, 8'h14);
        cycle(8'h00, 1'b1, 8'h00, 32'h0000_0000, 8'h08);

        // R9 R4: rising edge on ch0 with rise enable cleared; latch after 3 edges
        cycle(8'h00, 1'b1, 8'h04, 32'h0000_0000, 8'h1C);
        cycle(8'h01, 1'b0, 8'h00, 32'd0, 8'h1C);
        idle(3, 8'h1C);
        // R5: enabled rising edge on ch1 gives sticky status
        cycle(8'h01, 1'b1, 8'h04, 32'h0000_0002, 8'h24);
        cycle(8'h03, 1'b0, 8'h00, 32'd0, 8'h24);
        idle(4, 8'h24);
        // R6: write-one-to-clear of status, zero bits untouched
        cycle(8'h03, 1'b1, 8'h24, 32'h0000_0000, 8'h24);
        cycle(8'h03, 1'b1, 8'h24, 32'h0000_0002, 8'h24);
        // R7: edge lands in the same cycle as a clear of its latch bit
        cycle(8'h07, 1'b0, 8'h00, 32'd0, 8'h1C);
        cycle(8'h07, 1'b0, 8'h00, 32'd0, 8'h1C);
        cycle(8'h07, 1'b1, 8'h1C, 32'h0000_00FF, 8'h1C);
        idle(1, 8'h1C);
        // R7: same for status of ch3 with rise enable
        cycle(8'h07, 1'b1, 8'h04, 32'h0000_0008, 8'h24);
        cycle(8'h0F, 1'b0, 8'h00, 32'd0, 8'h24);
        cycle(8'h0F, 1'b0, 8'h00, 32'd0, 8'h24);
        cycle(8'h0F, 1'b1, 8'h24, 32'h0000_00FF, 8'h24);
        idle(1, 8'h24);
        // R8: level mode, active-high on ch4 and active-low on ch5
        cycle(8'h0F, 1'b1, 8'h00, 32'h0000_0030, 8'h00);
        cycle(8'h0F, 1'b1, 8'h04, 32'h0000_0030, 8'h24);
        cycle(8'h0F, 1'b1, 8'h10, 32'h0000_0010, 8'h24);
        cycle(8'h1F, 1'b0, 8'h00, 32'd0, 8'h24);
        idle(2, 8'h24);
        cycle(8'h3F, 1'b0, 8'h00, 32'd0, 8'h24);
        idle(2, 8'h24);
        cycle(8'h2F, 1'b1, 8'h24, 32'h0000_00FF, 8'h24);
        idle(3, 8'h24);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] np;
            logic       we;
            logic [7:0] wa;
            logic [31:0] wdat;
            np   = cur_pins ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            we   = ($urandom % 10) < 4;
            wa   = pick_addr($urandom);
            wdat = $urandom;
            cycle(np, we, wa, wdat, pick_addr($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule